// File: doc/BRIEF.md
# Hiccup Overcurrent Protection Sequencer

This block watches the per-cycle current-limit flag of a switching regulator and decides when to shut the converter down for a hiccup pause, when to let soft start run again, and when to ask for a clamp on the soft-start level. Once per switching cycle a strobe arrives together with a flag that says whether the current limit was hit in that cycle. The block keeps an overload count of such cycles and a run length of clean cycles. When enough overloaded cycles pile up, it turns the gate drives off, discharges soft start and starts the restart timer. It stays in that pause until a comparator reports that the timer has expired.

The analog parts sit outside the block: current sources, the restart-timer comparator and the clamp circuit. They appear here only as single-bit inputs and outputs. A mode input selects between forced PWM and diode emulation, and the mode decides when the soft-start clamp is requested. An enable input turns the whole shutdown function on or off.

Top module: `hiccup_seq`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to the running state with both counters at zero and all four outputs low.
- R2: Each cycle strobe that has `ilim_hit` high adds one to the overload count, which saturates at 512. A run of one to three clean strobes leaves the count unchanged, so overloaded cycles separated by short clean runs still accumulate.
- R3: A fourth clean strobe in a row clears the overload count.
- R4: With `hic_en` high, the strobe that brings the overload count to 512 causes `gate_off`, `ss_dischg` and `rtmr_chg` to go high at the second rising clock edge after that strobe.
- R5: While the hiccup pause is in progress, cycle strobes have no effect, with or without `ilim_hit`. The outputs stay high until `rtmr_done` arrives.
- R6: At the clock edge where `rtmr_done` is seen during the pause, `gate_off`, `ss_dischg` and `rtmr_chg` go low and both counters clear. The next strobe returns the sequencer to running without being counted.
- R7: With `hic_en` low, no number of overloaded cycles asserts `gate_off`, `ss_dischg` or `rtmr_chg`.
- R8: With `mode_fpwm` high (forced PWM), `ss_clamp` is high from the next rising clock edge on, whatever the overload count is.
- R9: With `mode_fpwm` low (diode emulation), `ss_clamp` goes high at the edge where the overload count reaches 32. It stays high until the count is cleared, either by R3 or by R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_stb | input | 1 | One-clock pulse marking the end of each switching cycle |
| ilim_hit | input | 1 | Current limit was reached in the cycle marked by the strobe |
| hic_en | input | 1 | Enables the hiccup shutdown |
| mode_fpwm | input | 1 | 1 = forced PWM, 0 = diode emulation |
| rtmr_done | input | 1 | Restart timer has reached its threshold |
| gate_off | output | 1 | Disables high-side and low-side gate drives |
| ss_dischg | output | 1 | Requests discharge of the soft-start capacitor |
| rtmr_chg | output | 1 | Enables charging of the restart timer (low = discharge) |
| ss_clamp | output | 1 | Requests the soft-start clamp above feedback |

## Verification
Overload bursts of 31, 32, 511 and 512 cycles find the clamp and shutdown thresholds to within one cycle. A burst followed by three or four clean cycles shows whether the clear depends on the run length. A burst of 500, then three clean cycles, then 12 more overloaded cycles still causes shutdown, which shows that a short clean run does not reset the count. Hit strobes during the pause, and a hit strobe in the restart state followed by 511 more hits, show that the pause ignores strobes and that the counters really restart from zero.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

    localparam int unsigned OVL_LIMIT_DEF = 512;
    localparam int unsigned CLAMP_TH_DEF  = 32;
    localparam int unsigned CLEAN_RUN_DEF = 4;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HWAIT   = 2'd1,
        ST_RESTART = 2'd2
    } hic_state_e;

    typedef struct packed {
        logic gate_off;
        logic ss_dischg;
        logic rtmr_chg;
    } hic_drv_t;

    function automatic hic_drv_t drv_of(input hic_state_e st);
        hic_drv_t d;
        d.gate_off  = (st == ST_HWAIT);
        d.ss_dischg = (st == ST_HWAIT);
        d.rtmr_chg  = (st == ST_HWAIT);
        return d;
    endfunction

endpackage

// File: rtl/hiccup_ovl_cnt.sv
module hiccup_ovl_cnt
    import hiccup_pkg::*;
#(
    parameter int unsigned OVL_LIMIT = OVL_LIMIT_DEF,
    parameter int unsigned CLAMP_TH  = CLAMP_TH_DEF,
    parameter int unsigned CLEAN_RUN = CLEAN_RUN_DEF,
    localparam int unsigned OVL_W    = $clog2(OVL_LIMIT + 1),
    localparam int unsigned CLN_W    = $clog2(CLEAN_RUN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic hit,
    input  logic clr,
    output logic trip,
    output logic lvl_nxt
);

    localparam logic [OVL_W-1:0] LIM = OVL_W'(OVL_LIMIT);
    localparam logic [OVL_W-1:0] CTH = OVL_W'(CLAMP_TH);
    localparam logic [CLN_W-1:0] RUN = CLN_W'(CLEAN_RUN);

    logic [OVL_W-1:0] ovl_q, ovl_d;
    logic [CLN_W-1:0] cln_q, cln_d;

    always_comb begin
        ovl_d = ovl_q;
        cln_d = cln_q;
        if (clr) begin
            ovl_d = '0;
            cln_d = '0;
        end else if (step) begin
            if (hit) begin
                cln_d = '0;
                if (ovl_q != LIM) ovl_d = ovl_q + 1'b1;
            end else begin
                if (cln_q != RUN) cln_d = cln_q + 1'b1;
                if (cln_d == RUN) ovl_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovl_q <= '0;
            cln_q <= '0;
        end else begin
            ovl_q <= ovl_d;
            cln_q <= cln_d;
        end
    end

    assign trip    = (ovl_q == LIM);
    assign lvl_nxt = (ovl_d >= CTH);

    p_sat_r2: assert property (@(posedge clk) disable iff (rst)
        ovl_q <= LIM);
    p_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (step && hit && !clr && ovl_q != LIM) |=> ovl_q == $past(ovl_q) + 1'b1);
    p_short_clean_r2: assert property (@(posedge clk) disable iff (rst)
        (step && !hit && !clr && cln_q < RUN - 1'b1) |=> $stable(ovl_q));
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !hit && cln_q == RUN - 1'b1) |=> ovl_q == '0);
    p_clr_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ovl_q == '0 && cln_q == '0));

endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
    import hiccup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cyc_stb,
    input  logic       hic_en,
    input  logic       trip,
    input  logic       rtmr_done,
    output logic       cnt_step,
    output logic       cnt_clr,
    output hic_state_e state
);

    hic_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:     if (hic_en && trip) st_d = ST_HWAIT;
            ST_HWAIT:   if (rtmr_done)      st_d = ST_RESTART;
            ST_RESTART: if (cyc_stb)        st_d = ST_RUN;
            default:                        st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RUN;
        else     st_q <= st_d;
    end

    assign cnt_step = cyc_stb && (st_q == ST_RUN);
    assign cnt_clr  = (st_q == ST_HWAIT) && rtmr_done;
    assign state    = st_q;

    p_enter_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && hic_en && trip) |=> st_q == ST_HWAIT);
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HWAIT && !rtmr_done) |=> st_q == ST_HWAIT);
    p_off_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && !hic_en) |=> st_q == ST_RUN);
    p_back_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RESTART && cyc_stb) |=> st_q == ST_RUN);

endmodule

// File: rtl/hiccup_clamp.sv
module hiccup_clamp (
    input  logic clk,
    input  logic rst,
    input  logic mode_fpwm,
    input  logic lvl_nxt,
    output logic clamp
);

    logic clamp_q;

    always_ff @(posedge clk) begin
        if (rst) clamp_q <= 1'b0;
        else     clamp_q <= mode_fpwm | lvl_nxt;
    end

    assign clamp = clamp_q;

    p_fpwm_r8: assert property (@(posedge clk) disable iff (rst)
        mode_fpwm |=> clamp_q);

endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq
    import hiccup_pkg::*;
#(
    parameter int unsigned OVL_LIMIT = OVL_LIMIT_DEF,
    parameter int unsigned CLAMP_TH  = CLAMP_TH_DEF,
    parameter int unsigned CLEAN_RUN = CLEAN_RUN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_stb,
    input  logic ilim_hit,
    input  logic hic_en,
    input  logic mode_fpwm,
    input  logic rtmr_done,
    output logic gate_off,
    output logic ss_dischg,
    output logic rtmr_chg,
    output logic ss_clamp
);

    logic       trip, lvl_nxt, cnt_step, cnt_clr;
    hic_state_e state;
    hic_drv_t   drv;

    hiccup_ovl_cnt #(
        .OVL_LIMIT (OVL_LIMIT),
        .CLAMP_TH  (CLAMP_TH),
        .CLEAN_RUN (CLEAN_RUN)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step    (cnt_step),
        .hit     (ilim_hit),
        .clr     (cnt_clr),
        .trip    (trip),
        .lvl_nxt (lvl_nxt)
    );

    hiccup_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cyc_stb   (cyc_stb),
        .hic_en    (hic_en),
        .trip      (trip),
        .rtmr_done (rtmr_done),
        .cnt_step  (cnt_step),
        .cnt_clr   (cnt_clr),
        .state     (state)
    );

    hiccup_clamp u_clamp (
        .clk       (clk),
        .rst       (rst),
        .mode_fpwm (mode_fpwm),
        .lvl_nxt   (lvl_nxt),
        .clamp     (ss_clamp)
    );

    assign drv       = drv_of(state);
    assign gate_off  = drv.gate_off;
    assign ss_dischg = drv.ss_dischg;
    assign rtmr_chg  = drv.rtmr_chg;

    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        (gate_off && rtmr_done) |=> (!gate_off && !ss_dischg && !rtmr_chg));
    p_stb_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (gate_off && !rtmr_done) |=> (gate_off && ss_dischg && rtmr_chg));
    p_de_release_r9: assert property (@(posedge clk) disable iff (rst)
        (!mode_fpwm && gate_off && rtmr_done) |=> !ss_clamp);

endmodule

// File: tb/test_hiccup_seq.sv
module test_hiccup_seq;

    logic clk = 1'b0;
    logic rst, cyc_stb, ilim_hit, hic_en, mode_fpwm, rtmr_done;
    logic gate_off, ss_dischg, rtmr_chg, ss_clamp;
    int   n_chk = 0;
    int   n_bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    hiccup_seq i_hiccup_seq (
        .clk       (clk),
        .rst       (rst),
        .cyc_stb   (cyc_stb),
        .ilim_hit  (ilim_hit),
        .hic_en    (hic_en),
        .mode_fpwm (mode_fpwm),
        .rtmr_done (rtmr_done),
        .gate_off  (gate_off),
        .ss_dischg (ss_dischg),
        .rtmr_chg  (rtmr_chg),
        .ss_clamp  (ss_clamp)
    );

    typedef struct packed {
        logic [9:0] hits;
        logic [2:0] cleans;
        logic       fpwm;
        logic       clamp;
        logic       gate;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{10'd31,  3'd0, 1'b0, 1'b0, 1'b0},
        '{10'd32,  3'd0, 1'b0, 1'b1, 1'b0},
        '{10'd32,  3'd3, 1'b0, 1'b1, 1'b0},
        '{10'd32,  3'd4, 1'b0, 1'b0, 1'b0},
        '{10'd40,  3'd4, 1'b1, 1'b1, 1'b0},
        '{10'd0,   3'd0, 1'b1, 1'b1, 1'b0},
        '{10'd0,   3'd0, 1'b0, 1'b0, 1'b0},
        '{10'd511, 3'd0, 1'b0, 1'b1, 1'b0},
        '{10'd512, 3'd0, 1'b0, 1'b1, 1'b1}
    };

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic stb(input logic hit, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc_stb  = 1'b1;
            ilim_hit = hit;
            @(negedge clk);
            cyc_stb  = 1'b0;
            ilim_hit = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cyc_stb = 1'b0; ilim_hit = 1'b0;
        hic_en = 1'b1; mode_fpwm = 1'b1; rtmr_done = 1'b0;
        idle(3);
        // R1: reset holds every output low, even in forced PWM
        check("R1", "gate_off in reset", gate_off, 1'b0);
        check("R1", "ss_dischg in reset", ss_dischg, 1'b0);
        check("R1", "rtmr_chg in reset", rtmr_chg, 1'b0);
        check("R1", "ss_clamp in reset", ss_clamp, 1'b0);

        // table walk: R2 R3 R4 R8 R9 thresholds
        for (int v = 0; v < NV; v++) begin
            mode_fpwm = VEC[v].fpwm;
            do_reset();
            stb(1'b1, int'(VEC[v].hits));
            stb(1'b0, int'(VEC[v].cleans));
            idle(2);
            check(VEC[v].fpwm ? "R8" : "R9", $sformatf("clamp vec %0d", v),
                  ss_clamp, VEC[v].clamp);
            check("R4", $sformatf("gate_off vec %0d", v), gate_off, VEC[v].gate);
        end

        // R4: exact latency of shutdown after the 512th hit strobe
        mode_fpwm = 1'b0;
        do_reset();
        stb(1'b1, 512);
        check("R4", "gate_off one edge after trip strobe", gate_off, 1'b0);
        @(negedge clk);
        check("R4", "gate_off second edge", gate_off, 1'b1);
        check("R4", "ss_dischg", ss_dischg, 1'b1);
        check("R4", "rtmr_chg", rtmr_chg, 1'b1);

        // R5: strobes ignored during pause
        stb(1'b1, 10);
        stb(1'b0, 6);
        check("R5", "gate_off held", gate_off, 1'b1);
        check("R5", "rtmr_chg held", rtmr_chg, 1'b1);
        check("R9", "clamp held until clear", ss_clamp, 1'b1);

        // R6: timer expiry releases and clears
        @(negedge clk); rtmr_done = 1'b1;
        @(negedge clk); rtmr_done = 1'b0;
        check("R6", "gate_off released", gate_off, 1'b0);
        check("R6", "ss_dischg released", ss_dischg, 1'b0);
        check("R6", "rtmr_chg released", rtmr_chg, 1'b0);
        check("R6", "clamp cleared with counter", ss_clamp, 1'b0);
        // restart strobe with a hit is not counted; 511 more must not trip
        stb(1'b1, 1);
        stb(1'b1, 511);
        idle(2);
        check("R6", "restart strobe not counted", gate_off, 1'b0);
        stb(1'b1, 1);
        idle(2);
        check("R6", "trip after full 512 in run", gate_off, 1'b1);

        // R2: accumulation across short clean runs
        do_reset();
        stb(1'b1, 500);
        stb(1'b0, 3);
        stb(1'b1, 12);
        idle(2);
        check("R2", "accumulates across 3 clean", gate_off, 1'b1);

        // R3: 4 clean in middle resets accumulation
        do_reset();
        stb(1'b1, 500);
        stb(1'b0, 4);
        stb(1'b1, 12);
        idle(2);
        check("R3", "4 clean clears count", gate_off, 1'b0);
        check("R9", "clamp after 12 hits", ss_clamp, 1'b0);

        // R7: disabled hiccup never shuts down
        hic_en = 1'b0;
        do_reset();
        stb(1'b1, 600);
        idle(3);
        check("R7", "gate_off with hic_en low", gate_off, 1'b0);
        check("R7", "rtmr_chg with hic_en low", rtmr_chg, 1'b0);
        check("R2", "saturated count keeps clamp", ss_clamp, 1'b1);

        // R8: forced PWM clamp follows mode one edge later
        hic_en = 1'b1;
        do_reset();
        @(negedge clk); mode_fpwm = 1'b1;
        @(negedge clk);
        check("R8", "clamp after mode set", ss_clamp, 1'b1);
        mode_fpwm = 1'b0;
        @(negedge clk);
        check("R9", "clamp drops with zero count", ss_clamp, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule